// File: doc/BRIEF.md
# Serial Flash Busy-Poll and Power-State Sequencer

This block sits between a command framer and a byte-wide serial shifter for a paged serial flash. Once the framer has clocked out the opcode and address bytes of a program, transfer, erase or compare command, it pulses `start` with the poll operation selected. The sequencer then takes over chip select. It drives chip select high to launch the flash's internal operation and pulls it low again. It then reads the status byte over and over, sending the status opcode and one 0x00 filler byte each time. It stops when the ready bit of a received status byte is set. On completion it pulses `done`, holds the last status byte and reports whether the compare bit signalled a match. If the ready bit does not appear within a bounded number of reads, it pulses `timed_out` and returns to idle.

The block also runs the power transitions. A sleep operation sends the power-down opcode and releases chip select. From then on the block accepts only the wake operation. The wake operation sends the resume opcode and holds chip select high for a minimum quiet time before it reports completion. That time is counted in clock cycles derived from the clock-frequency parameter, with an optional extra margin.

While the block is idle and awake, chip select follows the framer's select request. In every other state the sequencer owns chip select.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset the block is idle and awake (`busy`=0, `asleep`=0, `done`=0, `timed_out`=0, `xfer_req`=0), and while idle and awake `cs_n` equals the inverse of `host_sel`.
- R2: An accepted operation first drives `cs_n` high for exactly CS_GAP cycles (default 2) and then low before the first byte request. The gap both resets the command decoder and launches the internal operation.
- R3: A poll operation (`op`=2'b00) performs status reads. Each read is two byte transfers with `cs_n` low, the first sending OP_STATUS (default 0xD7) and the second sending 0x00. Consecutive reads are separated by a `cs_n` high gap of CS_GAP cycles.
- R4: Polling stops at the first received filler-byte response whose bit READY_BIT (default 7) is 1. `done` then pulses for one cycle and `status` equals that byte.
- R5: `match` is updated together with `done` on a poll and equals the inverse of bit CMP_BIT (default 6) of the final status byte.
- R6: If MAX_POLLS (default 16) consecutive reads all return a ready bit of 0, `timed_out` pulses for one cycle, `done` does not pulse, and the block returns to idle. `done` and `timed_out` are never high together.
- R7: A sleep operation (`op`=2'b01) sends exactly one byte, OP_SLEEP (default 0xB9), then releases `cs_n` high, sets `asleep` and pulses `done`.
- R8: While `asleep`=1 and idle, `cs_n` stays high whatever `host_sel` is, and a `start` with any `op` other than 2'b10 has no effect: no byte request, `busy` stays 0 and no `done`.
- R9: A wake operation (`op`=2'b10) sends exactly one byte, OP_WAKE (default 0xAB). It then holds `cs_n` high with `busy`=1 for at least ceil(CLK_HZ/1e6)*HOLD_US + HOLD_EXTRA cycles (1750 at 50 MHz and 35 us), then clears `asleep` and pulses `done`.
- R10: `start` is ignored while `busy`=1, and `start` with `op`=2'b11 is ignored in every state.
- R11: Once raised, `xfer_req` stays high with `xfer_tx` stable until the cycle in which `xfer_ack` is high. Each acknowledged request is exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Select request from the command framer, passed to chip select while idle and awake |
| start | input | 1 | One-cycle strobe that starts the operation given by `op` |
| op | input | 2 | Operation: 00 poll, 01 sleep, 10 wake, 11 none |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | One-cycle completion of the requested byte |
| xfer_rx | input | 8 | Byte received during the completed transfer, valid with `xfer_ack` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timed_out | output | 1 | One-cycle pulse when polling gives up |
| status | output | 8 | Last received status byte |
| match | output | 1 | Compare result of the last completed poll (1 = equal) |
| asleep | output | 1 | Flash has been put into power-down |

## Verification
The assertions assume that the shifter raises `xfer_ack` for exactly one cycle per request, and only while `xfer_req` is high, with `xfer_rx` valid in that cycle. They also assume that `start` is a single-cycle strobe. The bench device model acknowledges each request once, after a programmable delay of zero or more cycles. It never acknowledges without a pending request, and it returns scripted busy and ready status bytes only on the filler byte of a frame. The bench raises `start` for one cycle at a time. Strobes that arrive during an operation or while asleep are driven on purpose to exercise the ignore rules.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    typedef enum logic [1:0] {
        OP_POLL  = 2'b00,
        OP_SLEEP = 2'b01,
        OP_WAKE  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SEL,
        ST_OPC,
        ST_FILL,
        ST_HOLD
    } st_e;

    typedef struct packed {
        logic ready;
        logic match;
    } stat_flags_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Quiet time in cycles: whole clock cycles per microsecond (rounded up) times
    // the microseconds, plus the user margin; never below one cycle.
    function automatic int unsigned quiet_cycles(input int unsigned clk_hz,
                                                 input int unsigned hold_us,
                                                 input int unsigned extra);
        int unsigned per_us;
        per_us = (clk_hz + 999_999) / 1_000_000;
        return max_u(per_us * hold_us + extra, 1);
    endfunction

    function automatic stat_flags_t decode_status(input logic [7:0] b,
                                                  input int unsigned rdy_bit,
                                                  input int unsigned cmp_bit);
        stat_flags_t f;
        f.ready = b[rdy_bit[2:0]];
        f.match = ~b[cmp_bit[2:0]];
        return f;
    endfunction

endpackage

// File: rtl/dfp_timer.sv
module dfp_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R9: a freshly loaded non-zero count is never reported as expired
    load_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/dfp_poll_ctr.sv
module dfp_poll_ctr #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned PW = $clog2(LIMIT + 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == PW'(LIMIT - 1));

    // R6: the read count never passes the limit
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < PW'(LIMIT));

endmodule

// File: rtl/dfp_status_eval.sv
module dfp_status_eval
    import dfp_pkg::*;
#(
    parameter int unsigned READY_BIT = 7,
    parameter int unsigned CMP_BIT   = 6
) (
    input  logic [7:0]  rx_byte,
    output stat_flags_t flags
);
    always_comb begin
        flags = decode_status(rx_byte, READY_BIT, CMP_BIT);
    end

    initial begin
        // R4
        ready_pos_chk: assert (READY_BIT < 8);
        // R5
        cmp_pos_chk: assert (CMP_BIT < 8);
    end

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
    import dfp_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned HOLD_US    = 35,
    parameter int unsigned HOLD_EXTRA = 0,
    parameter int unsigned CS_GAP     = 2,
    parameter int unsigned MAX_POLLS  = 16,
    parameter int unsigned READY_BIT  = 7,
    parameter int unsigned CMP_BIT    = 6,
    parameter logic [7:0]  OP_STATUS  = 8'hD7,
    parameter logic [7:0]  OP_SLEEP_B = 8'hB9,
    parameter logic [7:0]  OP_WAKE_B  = 8'hAB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_sel,
    input  logic       start,
    input  logic [1:0] op,
    output logic       cs_n,
    output logic       xfer_req,
    output logic [7:0] xfer_tx,
    input  logic       xfer_ack,
    input  logic [7:0] xfer_rx,
    output logic       busy,
    output logic       done,
    output logic       timed_out,
    output logic [7:0] status,
    output logic       match,
    output logic       asleep
);
    localparam int unsigned GAP_CYC  = max_u(CS_GAP, 1);
    localparam int unsigned HOLD_CYC = quiet_cycles(CLK_HZ, HOLD_US, HOLD_EXTRA);
    localparam int unsigned TW       = $clog2(max_u(HOLD_CYC, GAP_CYC) + 1);
    localparam int unsigned HW       = $clog2(HOLD_CYC + 2);

    st_e         st, st_nx;
    op_e         cur_op;
    op_e         req_op;
    logic        tmr_load;
    logic [TW-1:0] tmr_val;
    logic        tmr_zero;
    logic        poll_clr;
    logic        poll_inc;
    logic        at_limit;
    logic        accept;
    stat_flags_t flags;

    assign req_op = op_e'(op);

    dfp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dfp_poll_ctr #(.LIMIT(MAX_POLLS)) u_polls (
        .clk      (clk),
        .rst      (rst),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .at_limit (at_limit)
    );

    dfp_status_eval #(.READY_BIT(READY_BIT), .CMP_BIT(CMP_BIT)) u_eval (
        .rx_byte (xfer_rx),
        .flags   (flags)
    );

    // Which strobes are taken from idle
    always_comb begin
        if (asleep) begin
            accept = (req_op == OP_WAKE);
        end else begin
            accept = (req_op != OP_NONE);
        end
    end

    // Next state and side controls
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start && accept) begin
                    st_nx    = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_CYC - 1);
                    poll_clr = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_zero) st_nx = ST_SEL;
            end
            ST_SEL: begin
                st_nx = ST_OPC;
            end
            ST_OPC: begin
                if (xfer_ack) begin
                    unique case (cur_op)
                        OP_POLL:  st_nx = ST_FILL;
                        OP_WAKE: begin
                            st_nx    = ST_HOLD;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(HOLD_CYC - 1);
                        end
                        default:  st_nx = ST_IDLE;
                    endcase
                end
            end
            ST_FILL: begin
                if (xfer_ack) begin
                    if (flags.ready || at_limit) begin
                        st_nx = ST_IDLE;
                    end else begin
                        st_nx    = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(GAP_CYC - 1);
                        poll_inc = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_zero) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_op    <= OP_POLL;
            done      <= 1'b0;
            timed_out <= 1'b0;
            status    <= '0;
            match     <= 1'b0;
            asleep    <= 1'b0;
        end else begin
            st        <= st_nx;
            done      <= 1'b0;
            timed_out <= 1'b0;
            if (st == ST_IDLE && start && accept) begin
                cur_op <= req_op;
            end
            if (st == ST_OPC && xfer_ack && cur_op == OP_SLEEP) begin
                asleep <= 1'b1;
                done   <= 1'b1;
            end
            if (st == ST_FILL && xfer_ack) begin
                status <= xfer_rx;
                if (flags.ready) begin
                    done  <= 1'b1;
                    match <= flags.match;
                end else if (at_limit) begin
                    timed_out <= 1'b1;
                end
            end
            if (st == ST_HOLD && tmr_zero) begin
                asleep <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    // Pin drive from state
    always_comb begin
        unique case (st)
            ST_IDLE:                   cs_n = asleep ? 1'b1 : ~host_sel;
            ST_SEL, ST_OPC, ST_FILL:   cs_n = 1'b0;
            default:                   cs_n = 1'b1;
        endcase
    end

    assign xfer_req = (st == ST_OPC) || (st == ST_FILL);
    assign busy     = (st != ST_IDLE);

    always_comb begin
        if (st == ST_FILL) begin
            xfer_tx = 8'h00;
        end else begin
            unique case (cur_op)
                OP_SLEEP: xfer_tx = OP_SLEEP_B;
                OP_WAKE:  xfer_tx = OP_WAKE_B;
                default:  xfer_tx = OP_STATUS;
            endcase
        end
    end

    // Length of the current chip-select-high run, for the quiet-time check
    logic [HW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (!cs_n) begin
            hi_run <= '0;
        end else if (hi_run != '1) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));
    // R3
    cs_low_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !cs_n);
    // R6
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, timed_out}));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    sleep_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && !busy) |-> cs_n);
    // R9
    wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> (hi_run >= HW'(HOLD_CYC)));

endmodule

// File: tb/tb_flash_ready_poller.sv
module tb_flash_ready_poller;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b11;
    logic       cs_n;
    logic       xfer_req;
    logic [7:0] xfer_tx;
    logic       xfer_ack;
    logic [7:0] xfer_rx;
    logic       busy, done, timed_out, match, asleep;
    logic [7:0] status;

    localparam int HOLD_EXP = 1750;

    flash_ready_poller dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .start(start), .op(op),
        .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .busy(busy), .done(done),
        .timed_out(timed_out), .status(status), .match(match), .asleep(asleep)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Device model controls (written by tasks only)
    int         busy_n = 0;
    int         poll_base = 0;
    int         ack_dly = 0;
    logic [7:0] busy_stat = 8'h3C;
    logic [7:0] final_stat = 8'h80;
    logic       mon_clr = 1'b0;

    // Device model state
    logic [7:0] log_mem [64];
    int         nbytes = 0;
    int         polls = 0;
    int         idx = 0;
    int         dcnt = 0;
    logic       ack_r = 1'b0;
    logic [7:0] rx_r = 8'hFF;
    assign xfer_ack = ack_r;
    assign xfer_rx  = rx_r;

    always @(posedge clk) begin
        if (rst) begin
            ack_r <= 1'b0;
            idx   <= 0;
            dcnt  <= 0;
        end else begin
            if (cs_n) idx <= 0;
            if (ack_r) begin
                ack_r <= 1'b0;
            end else if (xfer_req) begin
                if (dcnt < ack_dly) begin
                    dcnt <= dcnt + 1;
                end else begin
                    dcnt <= 0;
                    ack_r <= 1'b1;
                    log_mem[nbytes % 64] <= xfer_tx;
                    nbytes <= nbytes + 1;
                    idx <= idx + 1;
                    if (idx == 1) begin
                        polls <= polls + 1;
                        rx_r <= ((polls - poll_base) < busy_n) ? busy_stat : final_stat;
                    end else begin
                        rx_r <= 8'hFF;
                    end
                end
            end
        end
    end

    // Chip-select high-run monitor
    int run = 0, min_run = 999999, max_run = 0, falls = 0, last_run = 0;
    always @(posedge clk) begin
        if (cs_n) begin
            run <= run + 1;
        end else begin
            if (run != 0 && !mon_clr) begin
                falls <= falls + 1;
                last_run <= run;
                if (run < min_run) min_run <= run;
                if (run > max_run) max_run <= run;
            end
            run <= 0;
        end
        if (mon_clr) begin
            min_run <= 999999;
            max_run <= 0;
            falls   <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] o);
        @(negedge clk);
        start = 1'b1;
        op = o;
        @(negedge clk);
        start = 1'b0;
        op = 2'b11;
    endtask

    task automatic wait_end(input int limit, output bit gd, output bit gt, output int cyc);
        gd = 0; gt = 0; cyc = 0;
        for (int i = 0; i < limit; i++) begin
            if (done) begin gd = 1; break; end
            if (timed_out) begin gt = 1; break; end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n idle host_sel=0", cs_n, 1);
        chk(busy == 0 && asleep == 0 && done == 0 && timed_out == 0 && xfer_req == 0,
            "R1 reset flags", {busy, asleep, done, timed_out, xfer_req}, 0);
        host_sel = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b0, "R1 cs_n follows host_sel", cs_n, 0);
    endtask

    task automatic t_poll(input int nbusy, input logic [7:0] fin, input int dly, input string tag);
        int b0; bit gd, gt; int cyc;
        busy_n = nbusy; final_stat = fin; ack_dly = dly; poll_base = polls;
        clear_mon();
        b0 = nbytes;
        issue(2'b00);
        wait_end(4000, gd, gt, cyc);
        chk(gd && !gt, {tag, " R4 done"}, gd, 1);
        chk(status == fin, {tag, " R4 status"}, status, fin);
        chk(match == ~fin[6], {tag, " R5 match"}, match, ~fin[6]);
        chk(nbytes - b0 == 2 * (nbusy + 1), {tag, " R3 byte count"}, nbytes - b0, 2 * (nbusy + 1));
        for (int i = 0; i < 2 * (nbusy + 1); i++) begin
            logic [7:0] e;
            e = (i % 2 == 0) ? 8'hD7 : 8'h00;
            chk(log_mem[(b0 + i) % 64] == e, {tag, " R3 byte value"}, log_mem[(b0 + i) % 64], e);
        end
        @(negedge clk);
        chk(done == 0, {tag, " R4 one-cycle done"}, done, 0);
        @(negedge clk);
        chk(falls == nbusy + 1, {tag, " R3 cs gaps"}, falls, nbusy + 1);
        chk(min_run == 2 && max_run == 2, {tag, " R2 gap length"}, min_run, 2);
        chk(busy == 0 && cs_n == 0, {tag, " R1 back to idle"}, busy, 0);
        ack_dly = 0;
    endtask

    task automatic t_timeout();
        int b0; bit gd, gt; int cyc;
        busy_n = 1000; poll_base = polls;
        b0 = nbytes;
        issue(2'b00);
        wait_end(4000, gd, gt, cyc);
        chk(gt && !gd, "R6 timeout pulse", gt, 1);
        chk(nbytes - b0 == 32, "R6 read count", nbytes - b0, 32);
        chk(done == 0, "R6 no done", done, 0);
        @(negedge clk);
        chk(timed_out == 0 && busy == 0, "R6 idle after timeout", busy, 0);
    endtask

    task automatic t_sleep();
        int b0; bit gd, gt; int cyc;
        b0 = nbytes;
        issue(2'b01);
        wait_end(200, gd, gt, cyc);
        chk(gd, "R7 done", gd, 1);
        chk(nbytes - b0 == 1, "R7 one byte", nbytes - b0, 1);
        chk(log_mem[b0 % 64] == 8'hB9, "R7 opcode", log_mem[b0 % 64], 8'hB9);
        @(negedge clk);
        chk(asleep == 1, "R7 asleep", asleep, 1);
        chk(cs_n == 1, "R8 cs_n high host_sel=1", cs_n, 1);
    endtask

    task automatic t_sleep_ignore();
        int b0; bit gd, gt; int cyc;
        b0 = nbytes;
        issue(2'b00);
        chk(busy == 0, "R8 poll ignored busy", busy, 0);
        wait_end(40, gd, gt, cyc);
        chk(!gd && !gt, "R8 no completion", gd, 0);
        chk(nbytes == b0, "R8 no bytes", nbytes - b0, 0);
        chk(cs_n == 1 && asleep == 1, "R8 still asleep", cs_n, 1);
    endtask

    task automatic t_wake();
        int b0; bit gd, gt; int cyc;
        b0 = nbytes;
        issue(2'b10);
        repeat (100) @(negedge clk);
        chk(busy == 1 && cs_n == 1, "R9 busy in quiet time", busy, 1);
        issue(2'b00);
        wait_end(4000, gd, gt, cyc);
        chk(gd, "R9 done", gd, 1);
        chk(cyc + 102 >= HOLD_EXP, "R9 elapsed cycles", cyc + 102, HOLD_EXP);
        chk(nbytes - b0 == 1, "R10 start while busy ignored", nbytes - b0, 1);
        chk(log_mem[b0 % 64] == 8'hAB, "R9 opcode", log_mem[b0 % 64], 8'hAB);
        repeat (2) @(negedge clk);
        chk(asleep == 0, "R9 awake", asleep, 0);
        chk(last_run >= HOLD_EXP, "R9 cs high hold", last_run, HOLD_EXP);
        chk(busy == 0, "R10 no late operation", busy, 0);
    endtask

    task automatic t_op_none();
        int b0;
        b0 = nbytes;
        issue(2'b11);
        repeat (5) @(negedge clk);
        chk(busy == 0 && nbytes == b0, "R10 op 11 ignored", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_poll(0, 8'h80, 0, "first-ready");
        t_poll(3, 8'hC0, 0, "after-busy");
        t_poll(1, 8'hA5, 3, "R11 slow-ack");
        t_timeout();
        t_op_none();
        t_sleep();
        t_sleep_ignore();
        t_wake();
        t_poll(0, 8'hBF, 0, "post-wake");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule